// File: doc/BRIEF.md
# Indirect PHY Register Access Port

This block is a small memory-mapped bridge through which software reaches the configuration registers inside a serial PHY. Software fills a handful of host registers: a write-data word, a lane-enable bit, the PHY reset controls and a command word. The command word carries the PHY register index, a rate-group select and a read or write request. From these the bridge runs one request/acknowledge cycle on a narrow PHY-side register bus. It then raises a sticky completion bit, which software polls. A read cycle leaves the returned PHY data in a read-data register.

The expected software sequence runs as follows. Enable the lane. Load the write data. Write the command word with the index, the rate-group bit and exactly one request bit. Poll completion. Read the result if the access was a read. Finally, write the command word back with both request bits clear, which ends the access. The same index can be programmed once per rate group by repeating the sequence with the rate-group bit toggled. A PHY reset control held in the reset register blocks all traffic to the PHY while it is asserted.

Top module: `phy_access_port`

## Requirements
- R1: After reset, every host register reads zero and the outputs phy_req, phy_rst and phy_soft_rst are low.
- R2: Host byte offsets are as follows: 0x00 is the command word (bits 10:0 read back), 0x04 is write data (full width), 0x08 is lane enable (bit 0, also driven on phy_lane), 0x0C is reset control (bits 1:0), 0x10 is read data and 0x14 is completion (bit 0). Offset 0x10 is read-only. Any other offset reads zero and ignores writes.
- R3: A write to offset 0x00 starts a PHY write when bit 8 goes from 0 to 1 while bit 9 is 0 in the written value. phy_req rises in the cycle after that host write. phy_we is 1, phy_addr carries bits 7:0 of the written value, phy_rate carries bit 10, and phy_wdata carries the write-data register. All of these hold steady while phy_req is high.
- R4: A 0-to-1 transition of bit 9, with bit 8 clear, starts a PHY read with phy_we at 0. The value on phy_rdata in the cycle phy_ack is seen is stored in the read-data register.
- R5: phy_req stays high until phy_ack is sampled high and drops in the following cycle. A new request is issued only after phy_ack has returned low.
- R6: The completion bit becomes 1 in the cycle after phy_ack is sampled high during a request. It stays 1 until it is cleared, and it clears again when a new command starts.
- R7: No request is issued in any of three cases: the written value has both bits 8 and 9 set; the requested bit was already set in the command register; or lane enable is 0.
- R8: A write to offset 0x00 with bits 9:8 both zero clears the completion bit in the next cycle and withdraws a pending request.
- R9: Reset-control bit 1 drives phy_rst and bit 0 drives phy_soft_rst. From the cycle after bit 1 is seen set, no request is outstanding or issued and completion is never set.
- R10: Issuing the same index twice with bit 10 toggled produces two PHY cycles that differ only in phy_rate.
- R11: When the clearing write of R8 lands in the same cycle as phy_ack, the clearing write wins. Completion stays 0 and the read-data register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | HADDR_W | Host byte offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read-back of the register at host_addr (combinational) |
| phy_req | output | 1 | PHY register cycle request |
| phy_we | output | 1 | 1 for a PHY write, 0 for a read |
| phy_addr | output | IDX_W | PHY register index |
| phy_rate | output | 1 | Rate-group select |
| phy_wdata | output | DATA_W | PHY write data |
| phy_lane | output | 1 | Lane select |
| phy_ack | input | 1 | PHY acknowledge |
| phy_rdata | input | DATA_W | PHY read data, valid with phy_ack |
| phy_rst | output | 1 | PHY reset |
| phy_soft_rst | output | 1 | PHY soft reset |

## Verification
The PHY acknowledge can arrive in the same clock as a host write that ends or blocks the access. That write is either the clearing command write or the write that sets the PHY reset bit. The bench drives the acknowledge by hand and places the clearing write on exactly that edge. It then judges the result through completion and read data read back at the host offsets: completion must stay 0 and read data must be unchanged. A reset write made while a request is pending, with no acknowledge, is judged by how long phy_req stays high. A per-cycle reference model covers every other interleaving of acknowledge latency with host writes.

// File: rtl/phy_acc_pkg.sv
// Shared constants and types for the indirect PHY access port.
// Assumes byte offsets on a word-aligned host bus.
package phy_acc_pkg;
    localparam int OFF_CMD   = 'h00;
    localparam int OFF_WDATA = 'h04;
    localparam int OFF_LANE  = 'h08;
    localparam int OFF_RST   = 'h0C;
    localparam int OFF_RDATA = 'h10;
    localparam int OFF_DONE  = 'h14;

    localparam int CMD_W    = 11;
    localparam int BIT_WR   = 8;
    localparam int BIT_RD   = 9;
    localparam int BIT_RATE = 10;
    localparam int RST_HARD = 1;
    localparam int RST_SOFT = 0;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_REL  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/phy_acc_regs.sv
// Host register file: stores the command, write data, lane and reset
// controls, detects command edges on writes to the command word and
// multiplexes read-back. Assumes IDX_W <= 8 and DATA_W >= CMD_W.
module phy_acc_regs
    import phy_acc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 8,
    parameter int HADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               seq_done,
    input  logic [DATA_W-1:0]  seq_rdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic [DATA_W-1:0]  wdata_q,
    output logic               lane_q,
    output logic [1:0]         rst_q,
    output logic               start_wr,
    output logic               start_rd,
    output logic               cmd_clear,
    output logic [IDX_W-1:0]   new_idx,
    output logic               new_rate
);
    logic [CMD_W-1:0] cmd_q;
    logic             cmd_wr;

    // Register storage, updated on host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            wdata_q <= '0;
            lane_q  <= 1'b0;
            rst_q   <= '0;
        end else if (host_we) begin
            case (host_addr)
                HADDR_W'(OFF_CMD):   cmd_q   <= host_wdata[CMD_W-1:0];
                HADDR_W'(OFF_WDATA): wdata_q <= host_wdata;
                HADDR_W'(OFF_LANE):  lane_q  <= host_wdata[0];
                HADDR_W'(OFF_RST):   rst_q   <= host_wdata[1:0];
                default: ;
            endcase
        end
    end

    // Command edge detection against the stored command word.
    always_comb begin
        cmd_wr    = host_we && (host_addr == HADDR_W'(OFF_CMD));
        start_wr  = cmd_wr && host_wdata[BIT_WR] && !host_wdata[BIT_RD] && !cmd_q[BIT_WR];
        start_rd  = cmd_wr && host_wdata[BIT_RD] && !host_wdata[BIT_WR] && !cmd_q[BIT_RD];
        cmd_clear = cmd_wr && !host_wdata[BIT_WR] && !host_wdata[BIT_RD];
        new_idx   = host_wdata[IDX_W-1:0];
        new_rate  = host_wdata[BIT_RATE];
    end

    // Read-back multiplexer.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            HADDR_W'(OFF_CMD):   host_rdata[CMD_W-1:0] = cmd_q;
            HADDR_W'(OFF_WDATA): host_rdata = wdata_q;
            HADDR_W'(OFF_LANE):  host_rdata[0] = lane_q;
            HADDR_W'(OFF_RST):   host_rdata[1:0] = rst_q;
            HADDR_W'(OFF_RDATA): host_rdata = seq_rdata;
            HADDR_W'(OFF_DONE):  host_rdata[0] = seq_done;
            default: ;
        endcase
    end
endmodule

// File: rtl/phy_acc_seq.sv
// Command sequencer: latches a started command, runs a four-phase
// req/ack cycle on the PHY bus, captures read data and keeps the sticky
// completion flag. Assumes the PHY holds ack until req falls.
module phy_acc_seq
    import phy_acc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic              cmd_clear,
    input  logic              lane_en,
    input  logic              hold,
    input  logic [IDX_W-1:0]  new_idx,
    input  logic              new_rate,
    input  logic [DATA_W-1:0] wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [IDX_W-1:0]  phy_addr,
    output logic              phy_rate,
    output logic [DATA_W-1:0] phy_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    seq_state_e state;

    // Handshake state, command latch, completion and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            phy_we    <= 1'b0;
            phy_addr  <= '0;
            phy_rate  <= 1'b0;
            phy_wdata <= '0;
            done      <= 1'b0;
            rdata     <= '0;
        end else begin
            if (cmd_clear) done <= 1'b0;
            if (hold) begin
                state <= SQ_IDLE;
            end else begin
                case (state)
                    SQ_IDLE: if ((start_wr || start_rd) && lane_en && !phy_ack) begin
                        state     <= SQ_REQ;
                        phy_we    <= start_wr;
                        phy_addr  <= new_idx;
                        phy_rate  <= new_rate;
                        phy_wdata <= wdata;
                        done      <= 1'b0;
                    end
                    SQ_REQ: if (cmd_clear) begin
                        state <= SQ_REL;
                    end else if (phy_ack) begin
                        state <= SQ_REL;
                        done  <= 1'b1;
                        if (!phy_we) rdata <= phy_rdata;
                    end
                    SQ_REL: if (!phy_ack) state <= SQ_IDLE;
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

    // Request is high exactly while waiting for the acknowledge.
    assign phy_req = (state == SQ_REQ);
endmodule

// File: rtl/phy_access_port.sv
// Top of the indirect PHY register access port: host register file plus
// command sequencer. Host reads are combinational on host_addr.
module phy_access_port
    import phy_acc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 8,
    parameter int HADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               phy_req,
    output logic               phy_we,
    output logic [IDX_W-1:0]   phy_addr,
    output logic               phy_rate,
    output logic [DATA_W-1:0]  phy_wdata,
    output logic               phy_lane,
    input  logic               phy_ack,
    input  logic [DATA_W-1:0]  phy_rdata,
    output logic               phy_rst,
    output logic               phy_soft_rst
);
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] seq_rdata;
    logic [1:0]        rst_q;
    logic              lane_q, seq_done;
    logic              start_wr, start_rd, cmd_clear, new_rate;
    logic [IDX_W-1:0]  new_idx;

    phy_acc_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .HADDR_W(HADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .seq_done(seq_done), .seq_rdata(seq_rdata),
        .host_rdata(host_rdata), .wdata_q(wdata_q), .lane_q(lane_q), .rst_q(rst_q),
        .start_wr(start_wr), .start_rd(start_rd), .cmd_clear(cmd_clear),
        .new_idx(new_idx), .new_rate(new_rate)
    );

    phy_acc_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .cmd_clear(cmd_clear), .lane_en(lane_q), .hold(rst_q[RST_HARD]),
        .new_idx(new_idx), .new_rate(new_rate), .wdata(wdata_q),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata), .phy_req(phy_req),
        .phy_we(phy_we), .phy_addr(phy_addr), .phy_rate(phy_rate),
        .phy_wdata(phy_wdata), .done(seq_done), .rdata(seq_rdata)
    );

    assign phy_lane     = lane_q;
    assign phy_rst      = rst_q[RST_HARD];
    assign phy_soft_rst = rst_q[RST_SOFT];
endmodule

// File: rtl/phy_access_port_chk.sv
// Protocol checker for phy_access_port, attached by bind.
module phy_access_port_chk
    import phy_acc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 8,
    parameter int HADDR_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_we,
    input logic [HADDR_W-1:0] host_addr,
    input logic [1:0]         host_cmd_bits,
    input logic               phy_req,
    input logic               phy_ack,
    input logic               phy_rst,
    input logic               phy_we,
    input logic [IDX_W-1:0]   phy_addr,
    input logic               phy_rate,
    input logic [DATA_W-1:0]  phy_wdata,
    input logic               done
);
    logic clr_wr;
    assign clr_wr = host_we && (host_addr == HADDR_W'(OFF_CMD)) && (host_cmd_bits == 2'b00);

    // R5: request held until acknowledged unless withdrawn or reset
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack && !phy_rst && !clr_wr) |=> phy_req);

    // R5: request released after acknowledge
    p_req_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ack) |=> !phy_req);

    // R3: command fields stable during a request
    p_fields_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && $past(phy_req)) |-> ($stable(phy_addr) && $stable(phy_we)
                                        && $stable(phy_rate) && $stable(phy_wdata)));

    // R9: no request once the PHY reset has settled
    p_no_req_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rst && $past(phy_rst)) |-> !phy_req);

    // R6: completion rises only after an acknowledged request
    p_done_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(phy_req && phy_ack && !phy_rst));

    // R8: clearing write removes completion
    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !done);
endmodule

bind phy_access_port phy_access_port_chk #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .HADDR_W(HADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_cmd_bits(host_wdata[9:8]), .phy_req(phy_req), .phy_ack(phy_ack),
    .phy_rst(phy_rst), .phy_we(phy_we), .phy_addr(phy_addr), .phy_rate(phy_rate),
    .phy_wdata(phy_wdata), .done(seq_done)
);

// File: tb/phy_access_port_tb.sv
module phy_access_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        phy_req, phy_we, phy_rate, phy_lane, phy_rst, phy_soft_rst;
    logic [7:0]  phy_addr;
    logic [31:0] phy_wdata;
    logic        phy_ack;
    logic [31:0] phy_rdata;

    // PHY responder controls
    int          auto_lat = 2;
    int          auto_cnt = 0;
    logic        auto_ack = 1'b0;
    logic [31:0] auto_rdata = '0;
    logic        man_en = 1'b0, man_ack = 1'b0;
    logic [31:0] man_rdata = '0;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign phy_ack   = man_en ? man_ack : auto_ack;
    assign phy_rdata = man_en ? man_rdata : auto_rdata;

    phy_access_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .phy_req(phy_req),
        .phy_we(phy_we), .phy_addr(phy_addr), .phy_rate(phy_rate),
        .phy_wdata(phy_wdata), .phy_lane(phy_lane), .phy_ack(phy_ack),
        .phy_rdata(phy_rdata), .phy_rst(phy_rst), .phy_soft_rst(phy_soft_rst)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Automatic PHY: acknowledge after auto_lat request cycles, hold until req falls.
    always @(negedge clk) begin
        if (auto_ack && !phy_req) begin
            auto_ack <= 1'b0;
            auto_cnt <= 0;
        end else if (phy_req && !auto_ack) begin
            if (auto_cnt + 1 >= auto_lat) begin
                auto_ack   <= 1'b1;
                auto_rdata <= {16'hD00D, 3'b000, phy_rate, 4'h0, phy_addr};
            end
            auto_cnt <= auto_cnt + 1;
        end else if (!phy_req) begin
            auto_cnt <= 0;
        end
    end

    // Behavioural reference model, advanced on each rising edge.
    logic [10:0] m_cmd;
    logic [31:0] m_wd, m_pwd, m_rd;
    logic        m_lane, m_we, m_rate, m_done;
    logic [1:0]  m_rst;
    logic [7:0]  m_idx;
    int          m_st;
    logic        cw, swr, srd, clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = '0; m_wd = '0; m_pwd = '0; m_rd = '0; m_lane = 0; m_we = 0;
            m_rate = 0; m_done = 0; m_rst = '0; m_idx = '0; m_st = 0;
        end else begin
            cw  = host_we && host_addr == 5'h00;
            swr = cw && host_wdata[8] && !host_wdata[9] && !m_cmd[8];
            srd = cw && host_wdata[9] && !host_wdata[8] && !m_cmd[9];
            clr = cw && !host_wdata[8] && !host_wdata[9];
            if (clr) m_done = 0;
            if (m_rst[1]) m_st = 0;
            else if (m_st == 0) begin
                if ((swr || srd) && m_lane && !phy_ack) begin
                    m_st = 1; m_we = swr; m_idx = host_wdata[7:0];
                    m_rate = host_wdata[10]; m_pwd = m_wd; m_done = 0;
                end
            end else if (m_st == 1) begin
                if (clr) m_st = 2;
                else if (phy_ack) begin
                    m_st = 2; m_done = 1;
                    if (!m_we) m_rd = phy_rdata;
                end
            end else if (!phy_ack) m_st = 0;
            if (host_we) begin
                if (host_addr == 5'h00) m_cmd = host_wdata[10:0];
                if (host_addr == 5'h04) m_wd = host_wdata;
                if (host_addr == 5'h08) m_lane = host_wdata[0];
                if (host_addr == 5'h0C) m_rst = host_wdata[1:0];
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: m_read = {21'h0, m_cmd};
            5'h04: m_read = m_wd;
            5'h08: m_read = {31'h0, m_lane};
            5'h0C: m_read = {30'h0, m_rst};
            5'h10: m_read = m_rd;
            5'h14: m_read = {31'h0, m_done};
            default: m_read = '0;
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk(phy_req === (m_st == 1), "R5 phy_req", {31'h0, phy_req}, {31'h0, m_st == 1});
            if (m_st == 1) begin
                chk(phy_we === m_we, "R3 phy_we", {31'h0, phy_we}, {31'h0, m_we});
                chk(phy_addr === m_idx, "R3 phy_addr", {24'h0, phy_addr}, {24'h0, m_idx});
                chk(phy_rate === m_rate, "R10 phy_rate", {31'h0, phy_rate}, {31'h0, m_rate});
                chk(phy_wdata === m_pwd, "R3 phy_wdata", phy_wdata, m_pwd);
            end
            chk(phy_rst === m_rst[1], "R9 phy_rst", {31'h0, phy_rst}, {31'h0, m_rst[1]});
            chk(phy_soft_rst === m_rst[0], "R9 phy_soft_rst", {31'h0, phy_soft_rst}, {31'h0, m_rst[0]});
            chk(phy_lane === m_lane, "R2 phy_lane", {31'h0, phy_lane}, {31'h0, m_lane});
            chk(host_rdata === m_read(host_addr), "R2 host_rdata", host_rdata, m_read(host_addr));
        end
    end

    task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 30 && v[0] !== 1'b1; i++) hread(5'h14, v);
        chk(v[0] === 1'b1, tag, v, 32'h1);
    endtask

    task automatic no_req(input string tag, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); #3;
            chk(phy_req === 1'b0, tag, {31'h0, phy_req}, 32'h0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R5 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] keep;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a <= 'h14; a += 4) begin
            hread(5'(a), v);
            chk(v === 32'h0, "R1 reset readback", v, 32'h0);
        end
        chk(phy_req === 1'b0 && phy_rst === 1'b0 && phy_soft_rst === 1'b0, "R1 reset outputs",
            {29'h0, phy_req, phy_rst, phy_soft_rst}, 32'h0);

        // R2: register offsets and field widths
        hwrite(5'h04, 32'hA5A5_5A5A);
        hwrite(5'h08, 32'hFFFF_FFFF);
        hread(5'h04, v); chk(v === 32'hA5A5_5A5A, "R2 write data readback", v, 32'hA5A5_5A5A);
        hread(5'h08, v); chk(v === 32'h1, "R2 lane readback", v, 32'h1);
        hwrite(5'h18, 32'hFFFF_FFFF);
        hread(5'h18, v); chk(v === 32'h0, "R2 unused offset", v, 32'h0);
        hwrite(5'h10, 32'h1234_5678);
        hread(5'h10, v); chk(v === 32'h0, "R2 read data is read-only", v, 32'h0);

        // R3, R6, R8: write command, completion, clear
        hwrite(5'h00, 32'h0000_0143);
        #3 chk(phy_req === 1'b1 && phy_we === 1'b1 && phy_addr === 8'h43 && phy_rate === 1'b0,
               "R3 write request fields", {22'h0, phy_req, phy_we, phy_rate, phy_addr},
               {22'h0, 3'b110, 8'h43});
        chk(phy_wdata === 32'hA5A5_5A5A, "R3 write data forwarded", phy_wdata, 32'hA5A5_5A5A);
        wait_done("R6 completion after write");
        // R7: same bit already set, no new cycle
        hwrite(5'h00, 32'h0000_0143);
        no_req("R7 no restart without edge", 4);
        hwrite(5'h00, 32'h0);
        hread(5'h14, v); chk(v === 32'h0, "R8 completion cleared", v, 32'h0);

        // R10: same index in the alternate rate group
        hwrite(5'h00, 32'h0000_0543);
        #3 chk(phy_rate === 1'b1 && phy_addr === 8'h43, "R10 alternate rate group",
               {23'h0, phy_rate, phy_addr}, {23'h0, 1'b1, 8'h43});
        wait_done("R10 completion alternate group");
        hwrite(5'h00, 32'h0);

        // R4: read command and captured data
        hwrite(5'h00, 32'h0000_0252);
        #3 chk(phy_we === 1'b0, "R4 read request direction", {31'h0, phy_we}, 32'h0);
        wait_done("R6 completion after read");
        hread(5'h10, v); chk(v === 32'hD00D_0052, "R4 read data captured", v, 32'hD00D_0052);
        hwrite(5'h00, 32'h0);

        // R7: both bits set; lane disabled
        hwrite(5'h00, 32'h0000_0352);
        no_req("R7 both request bits", 4);
        hwrite(5'h00, 32'h0);
        hwrite(5'h08, 32'h0);
        hwrite(5'h00, 32'h0000_0143);
        no_req("R7 lane disabled", 4);
        hwrite(5'h00, 32'h0);
        hwrite(5'h08, 32'h1);

        // R9: reset outputs and blocking
        hwrite(5'h0C, 32'h2);
        #3 chk(phy_rst === 1'b1 && phy_soft_rst === 1'b0, "R9 hard reset output",
               {30'h0, phy_rst, phy_soft_rst}, 32'h2);
        hwrite(5'h00, 32'h0000_0143);
        no_req("R9 blocked under reset", 4);
        hread(5'h14, v); chk(v === 32'h0, "R9 no completion under reset", v, 32'h0);
        hwrite(5'h00, 32'h0);
        hwrite(5'h0C, 32'h1);
        #3 chk(phy_rst === 1'b0 && phy_soft_rst === 1'b1, "R9 soft reset output",
               {30'h0, phy_rst, phy_soft_rst}, 32'h1);
        hwrite(5'h0C, 32'h0);

        // R9: reset while a request is pending
        auto_lat = 1000;
        hwrite(5'h00, 32'h0000_0144);
        #3 chk(phy_req === 1'b1, "R9 request pending before reset", {31'h0, phy_req}, 32'h1);
        hwrite(5'h0C, 32'h2);
        @(negedge clk); #3;
        chk(phy_req === 1'b0, "R9 pending request dropped", {31'h0, phy_req}, 32'h0);
        hwrite(5'h0C, 32'h0);
        hwrite(5'h00, 32'h0);

        // R8: clearing write withdraws a pending request
        hwrite(5'h00, 32'h0000_0145);
        #3 chk(phy_req === 1'b1, "R8 request pending", {31'h0, phy_req}, 32'h1);
        hwrite(5'h00, 32'h0);
        #3 chk(phy_req === 1'b0, "R8 request withdrawn", {31'h0, phy_req}, 32'h0);
        auto_lat = 2;
        repeat (3) @(negedge clk);

        // R11: clearing write on the acknowledge edge
        hread(5'h10, keep);
        man_en = 1'b1; man_ack = 1'b0; man_rdata = 32'h0BAD_0BAD;
        hwrite(5'h00, 32'h0000_0260);
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'h00; host_wdata = 32'h0; man_ack = 1'b1;
        @(negedge clk);
        host_we = 1'b0; man_ack = 1'b0;
        hread(5'h14, v); chk(v === 32'h0, "R11 completion stays clear", v, 32'h0);
        hread(5'h10, v); chk(v === keep, "R11 read data unchanged", v, keep);
        man_en = 1'b0;
        repeat (3) @(negedge clk);

        // R5: handshake after a long latency still completes cleanly
        auto_lat = 5;
        hwrite(5'h00, 32'h0000_0277);
        wait_done("R5 completion after long latency");
        hread(5'h10, v); chk(v === 32'hD00D_0077, "R4 read data long latency", v, 32'hD00D_0077);
        hwrite(5'h00, 32'h0);
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule